// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block connects a synchronous request port to an external 16-bit asynchronous static RAM with active-low chip, write and output enables and one active-low strobe per data byte. A requester presents a word address, write data and a per-byte mask whenever `ready` is high. The controller then produces a complete memory cycle. The cycle length comes from clock-cycle wait-state parameters, so the same RTL can be tuned to the memory's setup, pulse and hold times at any clock rate.

A write first places the address, chip enable and byte strobes on the pins and holds write enable high for a setup interval. It then holds write enable low for a fixed pulse. The data drivers switch on only part-way into that pulse and stay on through a hold interval after write enable rises. Output enable stays high for the whole write, so the memory never drives the bus while the controller does. A read holds chip enable, output enable and the selected strobes low for a wait interval and then captures the bus into a register. Bytes that were not requested return as zero, and `rd_valid` pulses for one cycle. Chip enable is released after every access, which also meets the rule that a control must be released while the address changes. A request whose mask selects no byte finishes at once and never touches the memory.

The data bus is exposed as an output word, a per-lane drive enable and an input word, for connection to bidirectional pad cells.

Top module: `sram_bytelane_ctrl`

## Requirements
- R1: After reset, and whenever idle, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_lane_n` is all ones, `mem_dq_oe` is 0, `ready` is 1 and `rd_valid` is 0.
- R2: For a write, `mem_ce_n`, the address and the strobes are driven at least ADDR_SETUP cycles before `mem_we_n` falls. `mem_lane_n[0]` (bits 7..0) is low when `req_mask[0]` is 1, and `mem_lane_n[1]` (bits 15..8) is low when `req_mask[1]` is 1. `mem_oe_n` stays 1 throughout.
- R3: During a write, `mem_we_n` is low for exactly WE_PULSE consecutive cycles.
- R4: A lane's drive enable rises only after `mem_we_n` has been low for DRV_DELAY cycles, and only on a selected lane. It stays on for DATA_HOLD cycles after `mem_we_n` rises, and it falls together with `mem_ce_n` and the strobes.
- R5: While `mem_ce_n` is low, the address and strobes do not change. `mem_ce_n` goes high between any two accesses.
- R6: For a read, `mem_ce_n` and `mem_oe_n` are low and `mem_we_n` is high for READ_WAIT cycles. The bus is then captured into `rd_data` and `rd_valid` pulses in the cycle in which `mem_oe_n` returns high. Bytes that were not selected read as zero.
- R7: A request with a mask of 00 never lowers `mem_ce_n` and leaves `ready` high. A read of this kind gives `rd_valid` with `rd_data` = 0 on the next cycle.
- R8: `ready` is high only while idle, and a request made while `ready` is low has no effect on the memory.
- R9: The controller never enables its data drivers while `mem_oe_n` is low.
- R10: Written bytes land only in the selected lanes, so partial writes merge with the existing word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte select, bit i = byte i |
| ready | output | 1 | Idle, request accepted this cycle |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | DATA_W/8 | Byte strobes, active low |
| mem_dq_o | output | DATA_W | Data to pads |
| mem_dq_oe | output | DATA_W/8 | Per-lane pad drive enable |
| mem_dq_i | input | DATA_W | Data from pads |

## Verification
The bench's memory model holds the existing words and returns a filler pattern on any lane that is not selected. Full-word writes and reads, lower-only and upper-only writes that must merge with the existing word, and single-lane reads that must zero the other byte tell lane gating apart from whole-word behaviour. Two addresses, one of them the top of the address space, catch errors in the address path. Mask-00 requests and requests made while the controller is busy separate "ignored" from "performed". A cycle monitor measures the setup, pulse, drive-delay, hold and read-wait lengths, and also watches for bus contention.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WSETUP,
      ST_WPULSE,
      ST_WHOLD,
      ST_RWAIT
   } ctrl_state_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             expired
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (count != '0) begin
         count <= count - 1'b1;
      end
   end

   assign expired = (count == '0);

endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_load,
   input  logic [LANE_W-1:0] wr_byte,
   input  logic              lane_sel,
   input  logic              drive,
   input  logic              sample,
   input  logic [LANE_W-1:0] pad_in,
   output logic [LANE_W-1:0] pad_out,
   output logic              pad_oe,
   output logic [LANE_W-1:0] rd_byte
);

   logic [LANE_W-1:0] wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= '0;
         rd_byte <= '0;
      end else begin
         if (wr_load) wr_q <= wr_byte;
         if (sample)  rd_byte <= lane_sel ? pad_in : '0;
      end
   end

   assign pad_out = wr_q;
   assign pad_oe  = drive & lane_sel;

endmodule

// File: rtl/sram_bytelane_ctrl.sv
module sram_bytelane_ctrl #(
   parameter int ADDR_W     = 19,
   parameter int DATA_W     = 16,
   parameter int ADDR_SETUP = 2,
   parameter int WE_PULSE   = 4,
   parameter int DRV_DELAY  = 1,
   parameter int DATA_HOLD  = 1,
   parameter int READ_WAIT  = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic                   req_wr,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   input  logic [DATA_W/8-1:0]    req_mask,
   output logic                   ready,
   output logic                   rd_valid,
   output logic [DATA_W-1:0]      rd_data,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic                   mem_ce_n,
   output logic                   mem_we_n,
   output logic                   mem_oe_n,
   output logic [DATA_W/8-1:0]    mem_lane_n,
   output logic [DATA_W-1:0]      mem_dq_o,
   output logic [DATA_W/8-1:0]    mem_dq_oe,
   input  logic [DATA_W-1:0]      mem_dq_i
);
   import sram_ctrl_pkg::*;

   localparam int LANES    = DATA_W / 8;
   localparam int MAX_WAIT = int'(max3(ADDR_SETUP, WE_PULSE, max3(DATA_HOLD, READ_WAIT, 1)));
   localparam int CNT_W    = $clog2(MAX_WAIT + 1);

   localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(ADDR_SETUP - 1);
   localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(WE_PULSE - 1);
   localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(DATA_HOLD - 1);
   localparam logic [CNT_W-1:0] LD_READ  = CNT_W'(READ_WAIT - 1);
   localparam logic [CNT_W-1:0] DRV_MARK = CNT_W'(WE_PULSE - DRV_DELAY);

   initial begin : p_param_chk
      assert (DATA_W % 8 == 0 && DATA_W >= 8) else $error("DATA_W must be whole bytes");
      assert (ADDR_W >= 1) else $error("ADDR_W must be positive");
      assert (ADDR_SETUP >= 1) else $error("ADDR_SETUP must be at least 1");
      assert (DATA_HOLD >= 1) else $error("DATA_HOLD must be at least 1");
      assert (READ_WAIT >= 1) else $error("READ_WAIT must be at least 1");
      assert (DRV_DELAY >= 1 && DRV_DELAY < WE_PULSE)
         else $error("DRV_DELAY must lie in 1..WE_PULSE-1");
   end

   ctrl_state_e      state;
   logic             drive;
   logic             accept, accept_op, accept_nil;
   logic             tmr_load, tmr_exp;
   logic [CNT_W-1:0] tmr_val, tmr_cnt;
   logic             sample;

   assign ready      = (state == ST_IDLE);
   assign accept     = ready && req_valid;
   assign accept_op  = accept && (req_mask != '0);
   assign accept_nil = accept && (req_mask == '0);

   // wait-state timer load selection
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state)
         ST_IDLE: begin
            tmr_load = accept_op;
            tmr_val  = req_wr ? LD_SETUP : LD_READ;
         end
         ST_WSETUP: begin
            tmr_load = tmr_exp;
            tmr_val  = LD_PULSE;
         end
         ST_WPULSE: begin
            tmr_load = tmr_exp;
            tmr_val  = LD_HOLD;
         end
         default: ;
      endcase
   end

   sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .count    (tmr_cnt),
      .expired  (tmr_exp)
   );

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         mem_ce_n   <= 1'b1;
         mem_we_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_lane_n <= '1;
         mem_addr   <= '0;
         drive      <= 1'b0;
         rd_valid   <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept_nil && !req_wr) begin
                  rd_valid <= 1'b1;
               end else if (accept_op) begin
                  mem_ce_n   <= 1'b0;
                  mem_lane_n <= ~req_mask;
                  mem_addr   <= req_addr;
                  if (req_wr) begin
                     state <= ST_WSETUP;
                  end else begin
                     state    <= ST_RWAIT;
                     mem_oe_n <= 1'b0;
                  end
               end
            end
            ST_WSETUP: begin
               if (tmr_exp) begin
                  state    <= ST_WPULSE;
                  mem_we_n <= 1'b0;
               end
            end
            ST_WPULSE: begin
               if (tmr_exp) begin
                  state    <= ST_WHOLD;
                  mem_we_n <= 1'b1;
               end else if (tmr_cnt <= DRV_MARK) begin
                  drive <= 1'b1;
               end
            end
            ST_WHOLD: begin
               if (tmr_exp) begin
                  state      <= ST_IDLE;
                  drive      <= 1'b0;
                  mem_ce_n   <= 1'b1;
                  mem_lane_n <= '1;
               end
            end
            ST_RWAIT: begin
               if (tmr_exp) begin
                  state      <= ST_IDLE;
                  rd_valid   <= 1'b1;
                  mem_ce_n   <= 1'b1;
                  mem_oe_n   <= 1'b1;
                  mem_lane_n <= '1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign sample = ((state == ST_RWAIT) && tmr_exp) || (accept_nil && !req_wr);

   // one I/O slice per byte lane
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sram_lane_io #(.LANE_W(8)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_load  (accept_op && req_wr),
         .wr_byte  (req_wdata[g*8 +: 8]),
         .lane_sel (~mem_lane_n[g]),
         .drive    (drive),
         .sample   (sample),
         .pad_in   (mem_dq_i[g*8 +: 8]),
         .pad_out  (mem_dq_o[g*8 +: 8]),
         .pad_oe   (mem_dq_oe[g]),
         .rd_byte  (rd_data[g*8 +: 8])
      );
   end

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
   parameter int ADDR_W     = 19,
   parameter int LANES      = 2,
   parameter int ADDR_SETUP = 2,
   parameter int WE_PULSE   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ready,
   input logic              req_valid,
   input logic [LANES-1:0]  req_mask,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [LANES-1:0]  mem_lane_n,
   input logic [LANES-1:0]  mem_dq_oe
);

   logic [15:0] setup_run;
   logic [15:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_run <= '0;
         low_run   <= '0;
      end else begin
         if (mem_ce_n)                             setup_run <= '0;
         else if (mem_we_n && mem_oe_n && setup_run != 16'hFFFF) setup_run <= setup_run + 1'b1;
         if (mem_we_n)                             low_run <= '0;
         else if (low_run != 16'hFFFF)             low_run <= low_run + 1'b1;
      end
   end

   // R2: setup interval before write enable falls
   a_r2_setup_before_we: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> (setup_run >= 16'(ADDR_SETUP)));
   // R2: output enable stays high during a write
   a_r2_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && !mem_ce_n));
   // R3: write pulse length
   a_r3_we_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (low_run == 16'(WE_PULSE)));
   // R4: drivers only on selected lanes, only inside an access
   a_r4_drive_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe != '0) |-> (((mem_dq_oe & mem_lane_n) == '0) && !mem_ce_n));
   // R5: address and strobes stable while selected
   a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_lane_n)));
   // R5: chip enable only falls after an idle cycle
   a_r5_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> $past(ready));
   // R6: valid pulse accompanies the end of a read
   a_r6_valid_at_read_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> rd_valid);
   // R7: empty mask never selects the memory
   a_r7_nil_no_ce: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req_valid && req_mask == '0) |=> (mem_ce_n && ready));
   // R8: ready only while idle
   a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (mem_ce_n && mem_we_n && mem_oe_n));
   // R9: no contention with the memory's outputs
   a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe != '0) |-> mem_oe_n);

endmodule

bind sram_bytelane_ctrl sram_ctrl_chk #(
   .ADDR_W     (ADDR_W),
   .LANES      (DATA_W / 8),
   .ADDR_SETUP (ADDR_SETUP),
   .WE_PULSE   (WE_PULSE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ready      (ready),
   .req_valid  (req_valid),
   .req_mask   (req_mask),
   .rd_valid   (rd_valid),
   .mem_addr   (mem_addr),
   .mem_ce_n   (mem_ce_n),
   .mem_we_n   (mem_we_n),
   .mem_oe_n   (mem_oe_n),
   .mem_lane_n (mem_lane_n),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_bytelane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_bytelane_ctrl;

   localparam int AW = 19;
   localparam int DW = 16;
   localparam int SETUP = 2, PULSE = 4, DDLY = 1, HOLD = 1, RWAIT = 3;

   typedef struct packed {
      logic          wr;
      logic [AW-1:0] addr;
      logic [DW-1:0] wdata;
      logic [1:0]    mask;
      logic [DW-1:0] exp;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 19'h00010, 16'h1234, 2'b11, 16'h0000},
      '{1'b1, 19'h7FFFF, 16'hBEEF, 2'b11, 16'h0000},
      '{1'b0, 19'h00010, 16'h0000, 2'b11, 16'h1234},
      '{1'b1, 19'h00010, 16'hAA55, 2'b01, 16'h0000},
      '{1'b0, 19'h00010, 16'h0000, 2'b11, 16'h1255},
      '{1'b1, 19'h00010, 16'h66CC, 2'b10, 16'h0000},
      '{1'b0, 19'h00010, 16'h0000, 2'b10, 16'h6600},
      '{1'b0, 19'h7FFFF, 16'h0000, 2'b01, 16'h00EF},
      '{1'b0, 19'h7FFFF, 16'h0000, 2'b11, 16'hBEEF}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_wr = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_mask = '0;
   logic ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n;
   logic [DW-1:0] rd_data, mem_dq_o, mem_dq_i;
   logic [AW-1:0] mem_addr;
   logic [1:0] mem_lane_n, mem_dq_oe;

   always #5 clk = ~clk;

   sram_bytelane_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ADDR_SETUP(SETUP), .WE_PULSE(PULSE),
      .DRV_DELAY(DDLY), .DATA_HOLD(HOLD), .READ_WAIT(RWAIT)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_lane_n(mem_lane_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
      .mem_dq_i(mem_dq_i));

   // ---------------- memory model and cycle monitor ----------------
   logic [DW-1:0] mem [256];
   logic          mem_rd_on;
   assign mem_rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
   for (genvar g = 0; g < 2; g++) begin : g_rd
      assign mem_dq_i[g*8 +: 8] = (mem_rd_on && !mem_lane_n[g]) ?
                                  mem[mem_addr[7:0]][g*8 +: 8] : 8'hA5;
   end

   logic       prev_win = 1'b0, prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1;
   logic [1:0] prev_oe_lanes = '0;
   logic [DW-1:0] prev_data = '0;
   logic [7:0]  prev_idx = '0;
   int setup_run = 0, we_low = 0, hold_run = 0, oe_low = 0, drv_lag = -1;
   int m_setup = -1, m_pulse = -1, m_lag = -1, m_hold = -1, m_rwait = -1;
   int contention = 0, ce_falls = 0, oe_close_novalid = 0;
   logic [AW-1:0] seen_addr = '0;

   always @(negedge clk) begin
      logic win;
      win = !mem_ce_n && !mem_we_n && (mem_lane_n != 2'b11);
      if (prev_win && !win) begin
         for (int i = 0; i < 2; i++)
            if (prev_oe_lanes[i]) mem[prev_idx][i*8 +: 8] = prev_data[i*8 +: 8];
      end
      if ((mem_dq_oe != 0) && !mem_oe_n) contention++;
      if (prev_ce && !mem_ce_n) ce_falls++;
      if (!mem_ce_n) seen_addr = mem_addr;
      // write setup
      if (mem_ce_n) setup_run = 0;
      else if (mem_we_n && mem_oe_n && prev_we) setup_run++;
      if (prev_we && !mem_we_n) begin m_setup = setup_run; we_low = 0; drv_lag = -1; end
      if (!mem_we_n) begin
         if (mem_dq_oe != 0 && drv_lag < 0) drv_lag = we_low;
         we_low++;
      end
      if (!prev_we && mem_we_n) begin m_pulse = we_low; m_lag = drv_lag; hold_run = 0; end
      if (mem_we_n && mem_dq_oe != 0) hold_run++;
      if (mem_ce_n && !prev_ce && mem_oe_n && prev_oe) m_hold = hold_run;
      // read wait
      if (!mem_oe_n) oe_low++;
      if (!prev_oe && mem_oe_n) begin m_rwait = oe_low; oe_low = 0;
         if (!rd_valid) oe_close_novalid++; end
      prev_win = win; prev_we = mem_we_n; prev_oe = mem_oe_n; prev_ce = mem_ce_n;
      prev_oe_lanes = mem_dq_oe & ~mem_lane_n; prev_data = mem_dq_o; prev_idx = mem_addr[7:0];
   end

   // ---------------- checking helpers ----------------
   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic run_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [1:0] m, output logic got, output logic [DW-1:0] rdv,
                         output int cycles);
      @(negedge clk);
      while (!ready) @(negedge clk);
      req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m;
      @(negedge clk);
      req_valid = 1'b0;
      got = 1'b0; rdv = '0; cycles = 1;
      for (int k = 0; k < 60; k++) begin
         if (rd_valid) begin got = 1'b1; rdv = rd_data; end
         if (ready) break;
         @(negedge clk);
         cycles++;
      end
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      report();
   end

   initial begin : main
      logic got;
      logic [DW-1:0] rdv;
      int cyc, falls0;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ce_n", mem_ce_n, 1); chk("R1 we_n", mem_we_n, 1); chk("R1 oe_n", mem_oe_n, 1);
      chk("R1 lanes", mem_lane_n, 2'b11); chk("R1 dq_oe", mem_dq_oe, 0);
      chk("R1 ready_in_reset", ready, 1); chk("R1 rd_valid", rd_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table walk
      for (int v = 0; v < NV; v++) begin
         run_op(VECS[v].wr, VECS[v].addr, VECS[v].wdata, VECS[v].mask, got, rdv, cyc);
         chk("R5 address on bus", seen_addr, VECS[v].addr);
         chk("R1 idle after op", {mem_ce_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe},
             {3'b111, 2'b11, 2'b00});
         if (VECS[v].wr) begin
            chk("R2 setup cycles", m_setup, SETUP);
            chk("R3 pulse cycles", m_pulse, PULSE);
            chk("R4 drive delay", m_lag, DDLY);
            chk("R4 drive hold", m_hold, HOLD);
            chk("R10 stored word", mem[VECS[v].addr[7:0]],
                (v == 0) ? 16'h1234 : (v == 1) ? 16'hBEEF : (v == 3) ? 16'h1255 : 16'h6655);
         end else begin
            chk("R6 rd_valid seen", got, 1);
            chk("R6 rd_data lanes", rdv, VECS[v].exp);
            chk("R6 read wait", m_rwait, RWAIT);
         end
      end
      chk("R9 contention", contention, 0);
      chk("R6 valid at oe release", oe_close_novalid, 0);

      // R7 empty-mask write and read
      falls0 = ce_falls;
      run_op(1'b1, 19'h00010, 16'hFFFF, 2'b00, got, rdv, cyc);
      chk("R7 nil write cycles", cyc, 1);
      chk("R7 nil write no ce", ce_falls, falls0);
      chk("R7 nil write mem", mem[8'h10], 16'h6655);
      run_op(1'b0, 19'h00010, 16'h0000, 2'b00, got, rdv, cyc);
      chk("R7 nil read valid", got, 1);
      chk("R7 nil read data", rdv, 0);
      chk("R7 nil read no ce", ce_falls, falls0);

      // R8 request during busy is ignored
      @(negedge clk);
      req_valid = 1'b1; req_wr = 1'b1; req_addr = 19'h00020; req_wdata = 16'h1111; req_mask = 2'b11;
      @(negedge clk);
      chk("R8 ready low when busy", ready, 0);
      req_addr = 19'h00030; req_wdata = 16'h2222;
      while (!ready) @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8 first write done", mem[8'h20], 16'h1111);
      chk("R8 busy request ignored", mem[8'h30], 16'h0000);
      run_op(1'b0, 19'h00030, 16'h0000, 2'b11, got, rdv, cyc);
      chk("R8 readback ignored addr", rdv, 16'h0000);
      chk("R5 ce gap count", ce_falls, falls0 + 2);
      chk("R9 contention final", contention, 0);

      report();
   end

endmodule